// File: doc/BRIEF.md
# Coherence Plane Snoop Hub

The hub owns one coherence plane of a four-socket shared-memory system. Every memory request from any socket, including one aimed at the requester's own local memory, enters the hub. The hub accepts one request per cycle and broadcasts a snoop for it to all four sockets. It then collects one snoop response from each socket and returns a single merged result to the requesting socket. That result is either "clean, take it from memory" or "dirty in socket N".

Requests that hit the same 64-byte line are strictly ordered. A later request for a line that already has an open transaction is not accepted until that transaction has retired. A small table of open transactions tracks the lines in flight, and its entry index is the tag that snoops and responses carry. When several sockets compete in one cycle, a rotating-priority arbiter picks the winner. A request whose plane-select bits do not match the hub's strap is consumed and flagged as an error instead of being snooped.

Top module: `snoop_hub`

## Requirements
- R1: The cycle after a request is accepted, all four bits of `snp_vld` are high for one cycle. In that cycle `snp_src` is the requesting socket (the requester is snooped too), `snp_line` is address bits AW-1:6 and `snp_tag` is the transaction tag.
- R2: Address bits 13:12 are compared with `plane_id`. On a mismatch the request is still accepted (`req_rdy` high), but no snoop follows and `plane_err` is high for exactly the cycle after acceptance.
- R3: A request is not accepted (`req_rdy` low) while an open transaction holds the same line, meaning equal address bits AW-1:6. Bits 5:0 play no part, and a request for a different line is unaffected.
- R4: When all DEPTH table entries are open, no in-plane request is accepted until one retires.
- R5: When all four sockets request continuously, any four consecutive grants cover each socket exactly once.
- R6: A transaction completes only once all four sockets have responded on its tag. Responses may come in any order and on separate cycles. `cpl_vld` rises the cycle after the last response and stays high for one cycle, with `cpl_dst` set to the requester and `cpl_line` to the line.
- R7: `cpl_dirty` is 1 if any socket responded with `rsp_dirty` set, and `cpl_owner` is then the lowest-numbered such socket. Otherwise `cpl_dirty` is 0 and `cpl_owner` is 0.
- R8: At most one bit of `req_rdy` is high in any cycle.
- R9: A synchronous reset (`rst` high at a clock edge) closes every open transaction and discards partially collected responses.
- R10: A response on a tag that is not open, or a second response from a socket that has already responded on that tag, has no effect on the merged result or on completion.
- R11: When several transactions are complete at once, they are reported on successive cycles, lowest tag first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| plane_id | input | 2 | Plane this hub serves |
| req_vld | input | 4 | Request valid, one bit per socket |
| req_addr | input | 4*AW | Request physical addresses, socket s in bits s*AW +: AW |
| req_rdy | output | 4 | Request accepted this cycle, one bit per socket |
| snp_vld | output | 4 | Snoop valid towards each socket |
| snp_src | output | 2 | Requesting socket of the snoop |
| snp_tag | output | TW | Transaction tag of the snoop |
| snp_line | output | AW-6 | Line address of the snoop |
| rsp_vld | input | 4 | Snoop response valid, one bit per socket |
| rsp_tag | input | 4*TW | Tag each socket responds to |
| rsp_dirty | input | 4 | Socket holds the line modified |
| cpl_vld | output | 1 | Completion valid |
| cpl_dst | output | 2 | Socket the completion is for |
| cpl_line | output | AW-6 | Line address of the completion |
| cpl_dirty | output | 1 | Line is dirty in another cache |
| cpl_owner | output | 2 | Socket that owns the dirty line |
| plane_err | output | 1 | Wrong-plane request was consumed |

## Verification
The bench targets a same-line request that differs only in its byte offset, which a design comparing too many address bits would wrongly let through. It sends responses out of order, repeated, and on a tag that is not open. A design that counted responses instead of tracking which sockets had answered would complete early or report a stale dirty owner. It fills the table to the last entry, makes two transactions finish in the same cycle, and resets the hub with partial responses outstanding. These cases expose a lost completion, a wrong completion order, or a leftover response that would close a fresh transaction on the reused tag. It also checks that a request with the wrong plane bits produces neither a snoop nor a table entry.

// File: rtl/snoop_hub_pkg.sv
package snoop_hub_pkg;
  localparam int NSOCK     = 4;
  localparam int SID_W     = 2;
  localparam int LINE_LSB  = 6;
  localparam int PLANE_LSB = 12;

  // Rotating priority pick: the first eligible socket at or after ptr.
  function automatic logic [SID_W:0] pick_rr(input logic [NSOCK-1:0] elig,
                                             input logic [SID_W-1:0] ptr);
    logic [SID_W-1:0] k;
    for (int i = 0; i < NSOCK; i++) begin
      k = ptr + SID_W'(i);
      if (elig[k]) return {1'b1, k};
    end
    return '0;
  endfunction

  // Lowest-numbered socket that reported the line modified.
  function automatic logic [SID_W:0] first_dirty(input logic [NSOCK-1:0] d);
    for (int i = 0; i < NSOCK; i++)
      if (d[i]) return {1'b1, SID_W'(i)};
    return '0;
  endfunction
endpackage

// File: rtl/snoop_hub_rr.sv
module snoop_hub_rr
  import snoop_hub_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NSOCK-1:0] elig,
  output logic             gnt_vld,
  output logic [SID_W-1:0] gnt_idx
);
  logic [SID_W-1:0] ptr;

  always_comb {gnt_vld, gnt_idx} = pick_rr(elig, ptr);

  always_ff @(posedge clk) begin
    if (rst)          ptr <= '0;
    else if (gnt_vld) ptr <= gnt_idx + 1'b1;
  end
endmodule

// File: rtl/snoop_hub_tracker.sv
module snoop_hub_tracker
  import snoop_hub_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LW    = 34,
  parameter int TW    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NSOCK*LW-1:0] probe_line,
  output logic [NSOCK-1:0]    hit,
  output logic                free_vld,
  output logic [TW-1:0]       free_idx,
  input  logic                alloc,
  input  logic [SID_W-1:0]    alloc_src,
  input  logic [LW-1:0]       alloc_line,
  input  logic [NSOCK-1:0]    rsp_vld,
  input  logic [NSOCK*TW-1:0] rsp_tag,
  input  logic [NSOCK-1:0]    rsp_dirty,
  output logic                done_vld,
  output logic [TW-1:0]       done_idx,
  output logic [SID_W-1:0]    done_src,
  output logic [LW-1:0]       done_line,
  output logic [NSOCK-1:0]    done_dirty
);
  logic [DEPTH-1:0] e_vld;
  logic [LW-1:0]    e_line [DEPTH];
  logic [SID_W-1:0] e_src  [DEPTH];
  logic [NSOCK-1:0] e_got  [DEPTH];
  logic [NSOCK-1:0] e_dty  [DEPTH];

  // One transaction slot per entry; the entry index is the tag.
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        e_vld[g]  <= 1'b0;
        e_got[g]  <= '0;
        e_dty[g]  <= '0;
        e_line[g] <= '0;
        e_src[g]  <= '0;
      end else if (alloc && free_idx == TW'(g)) begin
        e_vld[g]  <= 1'b1;
        e_line[g] <= alloc_line;
        e_src[g]  <= alloc_src;
        e_got[g]  <= '0;
        e_dty[g]  <= '0;
      end else if (done_vld && done_idx == TW'(g)) begin
        e_vld[g] <= 1'b0;
        e_got[g] <= '0;
      end else if (e_vld[g]) begin
        for (int s = 0; s < NSOCK; s++) begin
          if (rsp_vld[s] && rsp_tag[s*TW +: TW] == TW'(g) && !e_got[g][s]) begin
            e_got[g][s] <= 1'b1;
            e_dty[g][s] <= rsp_dirty[s];
          end
        end
      end
    end
  end

  // Lowest free slot for allocation.
  always_comb begin
    free_vld = 1'b0;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!e_vld[i]) begin
        free_vld = 1'b1;
        free_idx = TW'(i);
      end
    end
  end

  // Lowest fully answered slot retires this cycle.
  always_comb begin
    done_vld = 1'b0;
    done_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (e_vld[i] && (&e_got[i])) begin
        done_vld = 1'b1;
        done_idx = TW'(i);
      end
    end
  end

  assign done_src   = e_src[done_idx];
  assign done_line  = e_line[done_idx];
  assign done_dirty = e_dty[done_idx];

  // Line conflict check for every socket's request against every open slot.
  always_comb begin
    hit = '0;
    for (int s = 0; s < NSOCK; s++)
      for (int e = 0; e < DEPTH; e++)
        if (e_vld[e] && e_line[e] == probe_line[s*LW +: LW]) hit[s] = 1'b1;
  end
endmodule

// File: rtl/snoop_hub.sv
module snoop_hub
  import snoop_hub_pkg::*;
#(
  parameter int AW    = 40,
  parameter int DEPTH = 8,
  localparam int LW   = AW - LINE_LSB,
  localparam int TW   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          plane_id,
  input  logic [NSOCK-1:0]    req_vld,
  input  logic [NSOCK*AW-1:0] req_addr,
  output logic [NSOCK-1:0]    req_rdy,
  output logic [NSOCK-1:0]    snp_vld,
  output logic [SID_W-1:0]    snp_src,
  output logic [TW-1:0]       snp_tag,
  output logic [LW-1:0]       snp_line,
  input  logic [NSOCK-1:0]    rsp_vld,
  input  logic [NSOCK*TW-1:0] rsp_tag,
  input  logic [NSOCK-1:0]    rsp_dirty,
  output logic                cpl_vld,
  output logic [SID_W-1:0]    cpl_dst,
  output logic [LW-1:0]       cpl_line,
  output logic                cpl_dirty,
  output logic [SID_W-1:0]    cpl_owner,
  output logic                plane_err
);
  logic [NSOCK*LW-1:0] line_s;
  logic [NSOCK-1:0]    bad, hit, elig;
  logic                free_vld, gnt_vld;
  logic [TW-1:0]       free_idx, done_idx;
  logic [SID_W-1:0]    gnt_idx, done_src, own_idx;
  logic                acc_ok, acc_bad, done_vld, own_vld;
  logic [LW-1:0]       done_line;
  logic [NSOCK-1:0]    done_dirty;
  logic                snp_on;

  for (genvar s = 0; s < NSOCK; s++) begin : g_sock
    assign line_s[s*LW +: LW] = req_addr[s*AW + LINE_LSB +: LW];
    assign bad[s]  = req_addr[s*AW + PLANE_LSB +: 2] != plane_id;
    assign elig[s] = req_vld[s] & (bad[s] | (~hit[s] & free_vld));
  end

  snoop_hub_rr u_arb (
    .clk(clk), .rst(rst), .elig(elig), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
  );

  assign req_rdy = gnt_vld ? (NSOCK'(1) << gnt_idx) : '0;
  assign acc_ok  = gnt_vld & ~bad[gnt_idx];
  assign acc_bad = gnt_vld &  bad[gnt_idx];

  snoop_hub_tracker #(.DEPTH(DEPTH), .LW(LW), .TW(TW)) u_trk (
    .clk(clk), .rst(rst),
    .probe_line(line_s), .hit(hit),
    .free_vld(free_vld), .free_idx(free_idx),
    .alloc(acc_ok), .alloc_src(gnt_idx), .alloc_line(line_s[gnt_idx*LW +: LW]),
    .rsp_vld(rsp_vld), .rsp_tag(rsp_tag), .rsp_dirty(rsp_dirty),
    .done_vld(done_vld), .done_idx(done_idx), .done_src(done_src),
    .done_line(done_line), .done_dirty(done_dirty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      snp_on    <= 1'b0;
      snp_src   <= '0;
      snp_tag   <= '0;
      snp_line  <= '0;
      plane_err <= 1'b0;
    end else begin
      snp_on    <= acc_ok;
      plane_err <= acc_bad;
      if (acc_ok) begin
        snp_src  <= gnt_idx;
        snp_tag  <= free_idx;
        snp_line <= line_s[gnt_idx*LW +: LW];
      end
    end
  end

  assign snp_vld = {NSOCK{snp_on}};

  always_comb {own_vld, own_idx} = first_dirty(done_dirty);

  assign cpl_vld   = done_vld;
  assign cpl_dst   = done_src;
  assign cpl_line  = done_line;
  assign cpl_dirty = done_vld & own_vld;
  assign cpl_owner = (done_vld & own_vld) ? own_idx : '0;
endmodule

// File: rtl/snoop_hub_chk.sv
module snoop_hub_chk #(
  parameter int LW = 34
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    req_rdy,
  input logic [3:0]    snp_vld,
  input logic          plane_err,
  input logic          cpl_vld,
  input logic          cpl_dirty,
  input logic [1:0]    cpl_owner,
  input logic [LW-1:0] cpl_line,
  input logic          acc_ok,
  input logic          acc_bad
);
  assert_one_grant_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_rdy));

  assert_snoop_follows_R1: assert property (@(posedge clk) disable iff (rst)
    acc_ok |=> (snp_vld == 4'hF));

  assert_full_broadcast_R1: assert property (@(posedge clk) disable iff (rst)
    (snp_vld == 4'h0) || (snp_vld == 4'hF));

  assert_wrong_plane_R2: assert property (@(posedge clk) disable iff (rst)
    acc_bad |=> (plane_err && snp_vld == 4'h0));

  assert_clean_owner_R7: assert property (@(posedge clk) disable iff (rst)
    (cpl_vld && !cpl_dirty) |-> (cpl_owner == 2'd0));

  assert_one_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    (cpl_vld && $past(cpl_vld)) |-> (cpl_line != $past(cpl_line)));
endmodule

bind snoop_hub snoop_hub_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst(rst), .req_rdy(req_rdy), .snp_vld(snp_vld),
  .plane_err(plane_err), .cpl_vld(cpl_vld), .cpl_dirty(cpl_dirty),
  .cpl_owner(cpl_owner), .cpl_line(cpl_line), .acc_ok(acc_ok), .acc_bad(acc_bad)
);

// File: tb/sim_snoop_hub.sv
module sim_snoop_hub;
  localparam int AW = 40;
  localparam int DEPTH = 8;
  localparam int LW = AW - 6;
  localparam int TW = 3;

  logic            clk = 0;
  logic            rst = 1;
  logic [1:0]      plane_id = 2'd2;
  logic [3:0]      req_vld = '0;
  logic [4*AW-1:0] req_addr = '0;
  logic [3:0]      req_rdy, snp_vld, rsp_vld = '0, rsp_dirty = '0;
  logic [1:0]      snp_src, cpl_dst, cpl_owner;
  logic [TW-1:0]   snp_tag;
  logic [LW-1:0]   snp_line, cpl_line;
  logic [4*TW-1:0] rsp_tag = '0;
  logic            cpl_vld, cpl_dirty, plane_err;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  snoop_hub #(.AW(AW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .plane_id(plane_id), .req_vld(req_vld), .req_addr(req_addr),
    .req_rdy(req_rdy), .snp_vld(snp_vld), .snp_src(snp_src), .snp_tag(snp_tag),
    .snp_line(snp_line), .rsp_vld(rsp_vld), .rsp_tag(rsp_tag), .rsp_dirty(rsp_dirty),
    .cpl_vld(cpl_vld), .cpl_dst(cpl_dst), .cpl_line(cpl_line), .cpl_dirty(cpl_dirty),
    .cpl_owner(cpl_owner), .plane_err(plane_err)
  );

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] gaddr(input int ln, input logic [1:0] pl, input int off);
    return (AW'(ln) << 14) | (AW'(pl) << 12) | AW'(off);
  endfunction

  task automatic send_req(input int s, input logic [AW-1:0] a,
                          output logic acc, output logic [TW-1:0] tg);
    @(negedge clk);
    req_vld[s] = 1'b1;
    req_addr[s*AW +: AW] = a;
    #1 acc = req_rdy[s];
    @(negedge clk);
    req_vld[s] = 1'b0;
    tg = snp_tag;
  endtask

  task automatic rsp(input logic [3:0] m, input logic [TW-1:0] t, input logic [3:0] d);
    @(negedge clk);
    rsp_vld = m;
    for (int s = 0; s < 4; s++) rsp_tag[s*TW +: TW] = t;
    rsp_dirty = d;
    @(negedge clk);
    rsp_vld = '0;
    rsp_dirty = '0;
  endtask

  task automatic finish_tag(input logic [TW-1:0] t);
    rsp(4'hF, t, 4'h0);
    chk("R6 retire", 64'(cpl_vld), 64'd1);
  endtask

  task automatic t_reset();
    chk("R9 reset snp", 64'(snp_vld), 64'd0);
    chk("R9 reset cpl", 64'(cpl_vld), 64'd0);
    chk("R9 reset err", 64'(plane_err), 64'd0);
    chk("R9 reset rdy", 64'(req_rdy), 64'd0);
  endtask

  task automatic t_single();
    logic acc; logic [TW-1:0] t; logic [AW-1:0] a;
    a = gaddr(5, 2, 3);
    send_req(1, a, acc, t);
    chk("R1 accept", 64'(acc), 64'd1);
    chk("R1 broadcast", 64'(snp_vld), 64'hF);
    chk("R1 src", 64'(snp_src), 64'd1);
    chk("R1 line", 64'(snp_line), 64'(a[AW-1:6]));
    rsp(4'hF, t, 4'h0);
    chk("R6 cpl", 64'(cpl_vld), 64'd1);
    chk("R6 dst", 64'(cpl_dst), 64'd1);
    chk("R6 line", 64'(cpl_line), 64'(a[AW-1:6]));
    chk("R7 clean", 64'(cpl_dirty), 64'd0);
    @(negedge clk);
    chk("R6 pulse", 64'(cpl_vld), 64'd0);
    chk("R1 one snoop", 64'(snp_vld), 64'd0);
  endtask

  task automatic t_dirty();
    logic acc; logic [TW-1:0] t;
    send_req(0, gaddr(9, 2, 0), acc, t);
    rsp(4'b1000, t, 4'b0000);
    chk("R6 partial 1", 64'(cpl_vld), 64'd0);
    rsp(4'b0100, t, 4'b0100);
    chk("R6 partial 2", 64'(cpl_vld), 64'd0);
    rsp(4'b0001, t, 4'b0000);
    chk("R6 partial 3", 64'(cpl_vld), 64'd0);
    rsp(4'b0010, t, 4'b0000);
    chk("R6 out of order", 64'(cpl_vld), 64'd1);
    chk("R7 dirty", 64'(cpl_dirty), 64'd1);
    chk("R7 owner", 64'(cpl_owner), 64'd2);
    chk("R6 dst", 64'(cpl_dst), 64'd0);
    send_req(3, gaddr(10, 2, 0), acc, t);
    rsp(4'hF, t, 4'b1010);
    chk("R7 lowest owner", 64'(cpl_owner), 64'd1);
    chk("R7 dirty multi", 64'(cpl_dirty), 64'd1);
  endtask

  task automatic t_ignore();
    logic acc; logic [TW-1:0] t;
    send_req(2, gaddr(12, 2, 0), acc, t);
    rsp(4'b0010, t, 4'b0000);
    rsp(4'b0010, t, 4'b0010);
    rsp(4'b0100, t ^ TW'(1), 4'b0100);
    chk("R10 stray no cpl", 64'(cpl_vld), 64'd0);
    rsp(4'b1101, t, 4'b0000);
    chk("R10 cpl", 64'(cpl_vld), 64'd1);
    chk("R10 repeat ignored", 64'(cpl_dirty), 64'd0);
  endtask

  task automatic t_conflict();
    logic acc; logic [TW-1:0] ta, tb, tc, tx;
    send_req(0, gaddr(20, 2, 0), acc, ta);
    send_req(3, gaddr(20, 2, 42), acc, tx);
    chk("R3 same line held", 64'(acc), 64'd0);
    send_req(2, gaddr(21, 2, 0), acc, tb);
    chk("R3 other line", 64'(acc), 64'd1);
    finish_tag(ta);
    send_req(3, gaddr(20, 2, 42), acc, tc);
    chk("R3 after retire", 64'(acc), 64'd1);
    finish_tag(tb);
    finish_tag(tc);
  endtask

  task automatic t_rr();
    logic [3:0] seen; logic [TW-1:0] tg [4]; int g;
    seen = '0;
    @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      req_vld[s] = 1'b1;
      req_addr[s*AW +: AW] = gaddr(40 + s, 2, 0);
    end
    for (int k = 0; k < 4; k++) begin
      #1;
      chk("R8 one grant", 64'($countones(req_rdy)), 64'd1);
      g = 0;
      for (int s = 0; s < 4; s++) if (req_rdy[s]) g = s;
      seen[g] = 1'b1;
      @(negedge clk);
      req_vld[g] = 1'b0;
      tg[k] = snp_tag;
    end
    chk("R5 all served", 64'(seen), 64'hF);
    for (int k = 0; k < 4; k++) finish_tag(tg[k]);
  endtask

  task automatic t_full();
    logic acc; logic [TW-1:0] tg [DEPTH]; logic [TW-1:0] tx;
    for (int i = 0; i < DEPTH; i++) begin
      send_req(0, gaddr(60 + i, 2, 0), acc, tg[i]);
      chk("R4 fill", 64'(acc), 64'd1);
    end
    send_req(1, gaddr(70, 2, 0), acc, tx);
    chk("R4 full blocks", 64'(acc), 64'd0);
    finish_tag(tg[0]);
    send_req(1, gaddr(70, 2, 0), acc, tx);
    chk("R4 freed", 64'(acc), 64'd1);
    for (int i = 1; i < DEPTH; i++) finish_tag(tg[i]);
    finish_tag(tx);
  endtask

  task automatic t_dual();
    logic acc; logic [TW-1:0] ta, tb; logic [LW-1:0] la, lb;
    la = gaddr(80, 2, 0) >> 6;
    lb = gaddr(81, 2, 0) >> 6;
    send_req(0, gaddr(80, 2, 0), acc, ta);
    send_req(1, gaddr(81, 2, 0), acc, tb);
    rsp(4'b1110, ta, 4'h0);
    rsp(4'b1101, tb, 4'h0);
    chk("R11 none yet", 64'(cpl_vld), 64'd0);
    @(negedge clk);
    rsp_vld = 4'b0011;
    rsp_tag[0 +: TW] = ta;
    rsp_tag[TW +: TW] = tb;
    @(negedge clk);
    rsp_vld = '0;
    chk("R11 first", 64'(cpl_vld), 64'd1);
    chk("R11 lower tag first", 64'(cpl_line), 64'((ta < tb) ? la : lb));
    @(negedge clk);
    chk("R11 second", 64'(cpl_vld), 64'd1);
    chk("R11 second line", 64'(cpl_line), 64'((ta < tb) ? lb : la));
    @(negedge clk);
    chk("R11 drained", 64'(cpl_vld), 64'd0);
  endtask

  task automatic t_plane();
    logic acc; logic [TW-1:0] t;
    send_req(2, gaddr(90, 1, 0), acc, t);
    chk("R2 consumed", 64'(acc), 64'd1);
    chk("R2 err", 64'(plane_err), 64'd1);
    chk("R2 no snoop", 64'(snp_vld), 64'd0);
    @(negedge clk);
    chk("R2 err pulse", 64'(plane_err), 64'd0);
  endtask

  task automatic t_reset_mid();
    logic acc; logic [TW-1:0] t, t2;
    send_req(0, gaddr(100, 2, 0), acc, t);
    rsp(4'b0011, t, 4'b0001);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    chk("R9 cpl cleared", 64'(cpl_vld), 64'd0);
    chk("R9 snp cleared", 64'(snp_vld), 64'd0);
    send_req(1, gaddr(100, 2, 0), acc, t2);
    chk("R9 entry freed", 64'(acc), 64'd1);
    rsp(4'b1100, t2, 4'h0);
    chk("R9 partial dropped", 64'(cpl_vld), 64'd0);
    rsp(4'b0011, t2, 4'h0);
    chk("R9 cpl", 64'(cpl_vld), 64'd1);
    chk("R9 stale dirty gone", 64'(cpl_dirty), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_single();
    t_dirty();
    t_ignore();
    t_conflict();
    t_rr();
    t_full();
    t_dual();
    t_plane();
    t_reset_mid();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected end of test");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule